// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Result Registers

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter in a small microcontroller. Software writes one control register that holds a busy/start bit, a conversion-clock divider select and a single-ended/differential mode select. Setting the busy bit starts the conversion-clock prescaler and a sequencer. The sequencer spends one step sampling and then ten steps trying result bits from the most significant down. For each step it presents a trial code to the external comparator and keeps the trial bit when the comparator answers "trial at or below input".

When the last step finishes, the block stores the code in a pair of result registers, clears the busy bit, gates the conversion clock off and raises a one-cycle completion pulse for use as an interrupt. A running conversion ignores a second start. Writing zero to the busy bit aborts the conversion and leaves the old result in place. Writing one again, which may happen on the very next bus cycle, begins a fresh conversion.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00. In that register, bit 0 is busy, bit 1 is the divider select, bit 2 is the mode, and bits 7:3 read as zero. The result registers read 0x00 after reset.
- R2: Output `mode_diff` follows control bit 2 (0 = single-ended, 1 = differential).
- R3: While busy is 0, `conv_tick` stays low and the prescaler count is held at zero.
- R4: With divider select 1, the conversion clock ticks on every master clock, and the completion pulse is seen 11 cycles after the clock edge that captures the start write. With divider select 0, it ticks once every 16 master clocks and completion comes after 176 cycles.
- R5: When a conversion completes, hardware clears busy and `conv_tick` stops.
- R6: A control write with bit 0 set while busy is 1 is ignored. Busy, mode and divider select are unchanged, and the running conversion finishes at its original time.
- R7: A control write with bit 0 clear aborts a running conversion. A write of one on the next bus cycle starts a new conversion with full timing counted from that write.
- R8: Address 1 holds result bits 9:2. Address 2 holds result bits 1:0 in bit positions 7:6, and its bits 5:0 read as zero. Software may write both registers.
- R9: The result registers change only on a completed conversion or on a bus write to them. An aborted conversion leaves them unchanged.
- R10: A conversion first drives `sample` high for one conversion step with `dac_code` zero. It then tries bits 9 down to 0, and keeps each bit when `cmp_le` is 1. The stored result therefore equals the largest code at or below the input.
- R11: `done` is high for exactly one master clock cycle per completed conversion, and is not raised by an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 result high, 2 result low) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cmp_le | input | 1 | Comparator: trial code is at or below the input |
| dac_code | output | 10 | Trial code for the DAC |
| sample | output | 1 | Sample step in progress |
| conv_tick | output | 1 | Gated conversion-clock enable |
| mode_diff | output | 1 | Differential mode select to the analog side |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check four things: the conversion clock is gated off while idle; completion leaves busy clear and the completion pulse lasts one cycle; every start opens with the sample step; and a second start while busy changes nothing. They also check that the result registers hold still while the block is idle and no write arrives. Only the bench scenarios can show the exact completion latencies for both divider settings, the converged codes for several inputs including zero and full scale, and that an abort leaves the old result in place. The scenarios also show the back-to-back abort and restart timing and the packing of the result across the two registers.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RES_HI = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;

  localparam int CTRL_BUSY = 0;
  localparam int CTRL_PSC  = 1;
  localparam int CTRL_MODE = 2;

  typedef struct packed {
    logic mode;
    logic psc;
    logic busy;
  } ctrl_t;
endpackage

// File: rtl/adc_clk_prescale.sv
module adc_clk_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (bypass || (cnt_q == LAST));
    cnt_d = cnt_q;
    if (!run || bypass || (cnt_q == LAST)) cnt_d = '0;
    else                                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cmp_le,
  output logic [RES_W-1:0] trial_code,
  output logic             sample,
  output logic             finish,
  output logic [RES_W-1:0] final_code
);
  localparam int SW = $clog2(RES_W + 2);
  localparam logic [SW-1:0] LAST_STEP = SW'(RES_W);

  logic [SW-1:0]    step_q, step_d, shamt;
  logic [RES_W-1:0] acc_q, acc_d, mask;

  always_comb begin
    shamt      = LAST_STEP - step_q;
    sample     = run && (step_q == '0);
    mask       = (step_q == '0) ? '0 : (RES_W'(1) << shamt);
    trial_code = acc_q | mask;
    finish     = run && tick && (step_q == LAST_STEP);

    acc_d  = acc_q;
    step_d = step_q;
    if (!run) begin
      acc_d  = '0;
      step_d = '0;
    end else if (tick) begin
      if (cmp_le) acc_d = acc_q | mask;
      step_d = step_q + 1'b1;
    end
    final_code = acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      acc_q  <= '0;
    end else begin
      step_q <= step_d;
      acc_q  <= acc_d;
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] load_code,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_hi,
  output logic [7:0]       rd_lo,
  output logic [RES_W-1:0] res
);
  localparam int LO_W  = RES_W - 8;
  localparam int PAD_W = 8 - LO_W;

  logic [7:0]      hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (load) begin
      hi_d = load_code[RES_W-1:LO_W];
      lo_d = load_code[LO_W-1:0];
    end else begin
      if (wr_hi) hi_d = wdata;
      if (wr_lo) lo_d = wdata[7:PAD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_lo = {lo_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign rd_lo = lo_q[7:0];
    end
  endgenerate

  assign rd_hi = hi_q;
  assign res   = {hi_q, lo_q};
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_regs_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DIV   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             cmp_le,
  output logic [RES_W-1:0] dac_code,
  output logic             sample,
  output logic             conv_tick,
  output logic             mode_diff,
  output logic             done
);
  logic [1:0]       rst_sync_q;
  logic             srst_n;
  ctrl_t            ctrl_q, ctrl_d;
  logic             done_q, done_d;
  logic             ctrl_wr, ctrl_load, finish, res_load;
  logic [RES_W-1:0] final_code, res_val;
  logic [7:0]       rd_hi, rd_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  always_comb begin
    ctrl_wr   = bus_we && (bus_addr == ADDR_CTRL);
    ctrl_load = ctrl_wr && (!ctrl_q.busy || !bus_wdata[CTRL_BUSY]);
    res_load  = finish && !ctrl_load;
    ctrl_d    = ctrl_q;
    if (ctrl_load) begin
      ctrl_d.busy = bus_wdata[CTRL_BUSY];
      ctrl_d.psc  = bus_wdata[CTRL_PSC];
      ctrl_d.mode = bus_wdata[CTRL_MODE];
    end else if (finish) begin
      ctrl_d.busy = 1'b0;
    end
    done_d = res_load;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      done_q <= done_d;
    end
  end

  adc_clk_prescale #(.DIV(DIV)) u_psc (
    .clk    (clk),
    .rst_n  (srst_n),
    .run    (ctrl_q.busy),
    .bypass (ctrl_q.psc),
    .tick   (conv_tick)
  );

  adc_sar_seq #(.RES_W(RES_W)) u_sar (
    .clk        (clk),
    .rst_n      (srst_n),
    .run        (ctrl_q.busy),
    .tick       (conv_tick),
    .cmp_le     (cmp_le),
    .trial_code (dac_code),
    .sample     (sample),
    .finish     (finish),
    .final_code (final_code)
  );

  adc_result_regs #(.RES_W(RES_W)) u_res (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (res_load),
    .load_code (final_code),
    .wr_hi     (bus_we && (bus_addr == ADDR_RES_HI)),
    .wr_lo     (bus_we && (bus_addr == ADDR_RES_LO)),
    .wdata     (bus_wdata),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .res       (res_val)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CTRL_BUSY] = ctrl_q.busy;
        bus_rdata[CTRL_PSC]  = ctrl_q.psc;
        bus_rdata[CTRL_MODE] = ctrl_q.mode;
      end
      ADDR_RES_HI: bus_rdata = rd_hi;
      ADDR_RES_LO: bus_rdata = rd_lo;
      default:     bus_rdata = '0;
    endcase
  end

  assign mode_diff = ctrl_q.mode;
  assign done      = done_q;
endmodule

// File: rtl/adc_ctrl_regs_chk.sv
module adc_ctrl_regs_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             psc,
  input logic             mode,
  input logic             conv_tick,
  input logic             sample,
  input logic             done,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [RES_W-1:0] res
);
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_tick); // R3

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_we) |=> $stable(res)); // R9

  AST_SAMPLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sample); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_tick && bus_we && bus_addr == 2'd0 && bus_wdata[0])
      |=> (busy && $stable(psc) && $stable(mode))); // R6
endmodule

bind adc_ctrl_regs adc_ctrl_regs_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (ctrl_q.busy),
  .psc       (ctrl_q.psc),
  .mode      (ctrl_q.mode),
  .conv_tick (conv_tick),
  .sample    (sample),
  .done      (done),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .res       (res_val)
);

// File: tb/test_adc_ctrl_regs.sv
module test_adc_ctrl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [9:0] dac_code;
  logic [9:0] vin = 10'd0;
  logic       cmp_le, sample, conv_tick, mode_diff, done;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;
  assign cmp_le = (dac_code <= vin);

  adc_ctrl_regs i_adc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_le(cmp_le),
    .dac_code(dac_code), .sample(sample), .conv_tick(conv_tick),
    .mode_diff(mode_diff), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Start with ctrl byte, optionally poke the control register at cycle poke_at,
  // count edges until done is seen; also checks done lasts one cycle (R11).
  task automatic run_conv(input logic [7:0] ctrl, input int poke_at,
                          input logic [7:0] poke, output int n);
    bit seen = 1'b0;
    n = 0;
    bus_wr(2'd0, ctrl);
    while (!seen && n < 400) begin
      @(posedge clk);
      n++;
      #1 bus_we = 1'b0;
      @(negedge clk);
      if (done) seen = 1'b1;
      else if (n == poke_at) begin
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = poke;
      end
    end
    @(negedge clk);
    check("R11 done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(2'd0, d); check("R1 ctrl reset", d, 8'h00);
    bus_rd(2'd1, d); check("R1 result hi reset", d, 8'h00);
    bus_rd(2'd2, d); check("R1 result lo reset", d, 8'h00);
  endtask

  task automatic t_fields_idle();
    logic [7:0] d;
    int ticks = 0;
    bus_wr(2'd0, 8'hFE);
    bus_rd(2'd0, d); check("R1 ctrl readback, upper bits zero", d, 8'h06);
    check("R2 mode_diff high", int'(mode_diff), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (conv_tick) ticks++;
    end
    check("R3 no tick while idle", ticks, 0);
    bus_wr(2'd0, 8'h02);
    check("R2 mode_diff low", int'(mode_diff), 0);
  endtask

  task automatic t_fast(input logic [9:0] v);
    logic [7:0] d;
    int n;
    vin = v;
    run_conv(8'h03, 0, 8'h00, n);
    check("R4 fast latency", n, 11);
    bus_rd(2'd0, d); check("R5 busy cleared", d, 8'h02);
    check("R5 tick stopped", int'(conv_tick), 0);
    bus_rd(2'd1, d); check("R8/R10 result hi", d, int'(v[9:2]));
    bus_rd(2'd2, d); check("R8/R10 result lo", d, int'({v[1:0], 6'b0}));
  endtask

  task automatic t_sample_step();
    int n;
    vin = 10'h155;
    bus_wr(2'd0, 8'h03);
    @(negedge clk);
    check("R10 sample first", int'(sample), 1);
    check("R10 code zero during sample", int'(dac_code), 0);
    @(negedge clk);
    check("R10 sample ends", int'(sample), 0);
    check("R10 MSB trial", int'(dac_code), 10'h200);
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check("R10 conversion finished", int'(done), 1);
  endtask

  task automatic t_slow_ignore();
    logic [7:0] d;
    int n;
    vin = 10'h2C9;
    run_conv(8'h01, 20, 8'h07, n);
    check("R6 timing undisturbed", n, 176);
    bus_rd(2'd0, d); check("R6 fields unchanged", d, 8'h00);
    check("R6 mode unchanged", int'(mode_diff), 0);
    bus_rd(2'd1, d); check("R6 result hi", d, int'(vin[9:2]));
  endtask

  task automatic t_abort_restart();
    logic [7:0] d;
    logic [7:0] hi0, lo0;
    int n, seen;
    bus_rd(2'd1, hi0); bus_rd(2'd2, lo0);
    vin = 10'h0F3;
    bus_wr(2'd0, 8'h01);
    repeat (30) @(negedge clk);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, d); check("R7 abort clears busy", d, 8'h00);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R11 no done on abort", seen, 0);
    bus_rd(2'd1, d); check("R9 hi kept after abort", d, hi0);
    bus_rd(2'd2, d); check("R9 lo kept after abort", d, lo0);
    vin = 10'h3A7;
    bus_wr(2'd0, 8'h01);
    bus_wr(2'd0, 8'h00);
    run_conv(8'h01, 0, 8'h00, n);
    check("R7 restart full latency", n, 176);
    bus_rd(2'd1, d); check("R7 restart result hi", d, int'(vin[9:2]));
    bus_rd(2'd2, d); check("R7 restart result lo", d, int'({vin[1:0], 6'b0}));
  endtask

  task automatic t_sw_result();
    logic [7:0] d;
    bus_wr(2'd1, 8'hA5);
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd1, d); check("R8 sw write hi", d, 8'hA5);
    bus_rd(2'd2, d); check("R8 sw write lo bits 5:0 zero", d, 8'hC0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields_idle();
    t_fast(10'h2A5);
    t_fast(10'h000);
    t_fast(10'h3FF);
    t_sample_step();
    t_slow_ignore();
    t_abort_restart();
    t_sw_result();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule